// File: doc/BRIEF.md
# E1 Timeslot Drop-Insert Multiplexer

This block sits on a 2.048 Mbit/s serial PCM stream made of 32 eight-bit timeslots per 125 us frame. It runs one bit per clock. A frame pulse marks the first bit of each frame. A static ownership mask, loaded while the block is held in reset, names the timeslots that belong to the local node. Each slot carries 64 kbit/s, so enabling 1 to 31 slots gives a local payload of 64 to 1984 kbit/s.

In its own slots the block does two things. It drops each incoming octet into a local receive FIFO. It replaces the outgoing octet with the next byte from a local transmit FIFO. All other slots go straight through to the downstream line, so several nodes can share one chained line by each owning a different set of slots. Slot 0 carries framing and is never owned.

Both local byte interfaces use valid/ready. A byte moves only in a cycle where valid and ready are both high.
- On the receive side, `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low.
- On the transmit side, `tx_ready` falls when the transmit FIFO is full.

The line itself cannot wait. If the transmit FIFO is empty when an owned slot starts, an idle octet is sent. If the receive FIFO is full when an owned octet completes, that octet is lost. Each of these events is reported on a one-cycle flag.

Top module: `e1_slot_mux`

## Requirements
- R1: While reset is asserted, the outputs take these values: `ser_o` is 1, `rx_valid` is 0, `tx_ready` is 1, and `underrun_o` and `overrun_o` are 0.
- R2: In a slot that is not owned, `ser_o` in cycle t+1 equals `ser_i` in cycle t.
- R3: Slot 0 is always passed through, whatever the value of `slot_mask[0]`. A slot s from 1 to 31 is owned when `slot_mask[s]` is 1.
- R4: Slot timing has these rules:
  - A cycle with `fp_i` high is bit 7 (the MSB) of slot 0.
  - Each clock advances one bit, from bit 7 down to bit 0.
  - After bit 0, the count moves to bit 7 of the next slot.
  - After slot 31 it wraps to slot 0 even when no pulse arrives.
- R5: The octet received MSB first in each owned slot is pushed into the receive FIFO exactly once per frame. Octets leave on `rx_data` in arrival order.
- R6: In an owned slot, `ser_o` sends the next transmit FIFO byte MSB first, with the same one-cycle latency as R2. Each owned slot consumes at most one byte.
- R7: If the transmit FIFO is empty at bit 7 of an owned slot, the octet 8'hFF is sent. `underrun_o` is then high for one cycle, aligned with the first output bit of that octet.
- R8: If the receive FIFO is full when an owned octet completes, the octet is discarded and the FIFO contents are kept. `overrun_o` is then high for one cycle.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` does not change.
- R10: `tx_ready` is low exactly when the transmit FIFO holds its full depth. A byte offered while `tx_ready` is low is not taken.
- R11: A frame pulse that arrives in the middle of a frame realigns the count immediately to slot 0, bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_mask | input | 32 | Static slot ownership mask; bit 0 is ignored |
| fp_i | input | 1 | Frame pulse, high on bit 7 of slot 0 |
| ser_i | input | 1 | Incoming serial PCM bit |
| ser_o | output | 1 | Outgoing serial PCM bit, one cycle behind |
| rx_data | output | 8 | Dropped octet |
| rx_valid | output | 1 | Dropped octet available |
| rx_ready | input | 1 | Consumer accepts the dropped octet |
| tx_data | input | 8 | Byte to insert |
| tx_valid | input | 1 | Byte to insert is offered |
| tx_ready | output | 1 | Transmit FIFO has room |
| underrun_o | output | 1 | One-cycle pulse: idle octet inserted |
| overrun_o | output | 1 | One-cycle pulse: received octet discarded |

## Verification
The hardest case to reach is a single cycle that combines several events. In that cycle a FIFO is at its limit while an owned slot boundary lands on it, and a local handshake on the same FIFO happens too. An example is a push from the line into a full receive FIFO in the same cycle that the consumer pops.

To reach it, the stimulus throttles `rx_ready` and `tx_valid` by random percentages against dense and sparse masks. This lets the FIFO fill levels drift through their limits at slot boundaries. Directed phases add starvation and all-slot runs, frames with no pulse, and pulses injected mid-frame.

// File: rtl/e1_mux_pkg.sv
package e1_mux_pkg;
  localparam int OCTET_BITS = 8;
  localparam int BIT_W      = $clog2(OCTET_BITS);
  typedef logic [OCTET_BITS-1:0] octet_t;
  localparam octet_t IDLE_OCTET = 8'hFF;
endpackage

// File: rtl/e1_slot_timer.sv
module e1_slot_timer
  import e1_mux_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_i,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [BIT_W-1:0]  cur_bit
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  MSB_BIT   = BIT_W'(OCTET_BITS - 1);

  logic [SLOT_W-1:0] cnt_slot;
  logic [BIT_W-1:0]  cnt_bit;

  // A frame pulse overrides the free-running count in the same cycle.
  assign cur_slot = fp_i ? '0 : cnt_slot;
  assign cur_bit  = fp_i ? MSB_BIT : cnt_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_slot <= '0;
      cnt_bit  <= MSB_BIT;
    end else if (cur_bit == '0) begin
      cnt_bit  <= MSB_BIT;
      cnt_slot <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
    end else begin
      cnt_bit  <= cur_bit - 1'b1;
      cnt_slot <= cur_slot;
    end
  end
endmodule

// File: rtl/e1_byte_fifo.sv
module e1_byte_fifo
  import e1_mux_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  input  octet_t in_data,
  output logic   out_valid,
  input  logic   out_ready,
  output octet_t out_data
);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  octet_t          mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [AW:0]     count;
  logic            do_push, do_pop;

  assign in_ready  = (count != FULL_CNT);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/e1_slot_lane.sv
module e1_slot_lane
  import e1_mux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_i,
  input  logic             owned,
  input  logic [BIT_W-1:0] cur_bit,
  input  octet_t           tx_head,
  input  logic             tx_have,
  output logic             tx_take,
  input  logic             rx_room,
  output logic             rx_push,
  output octet_t           rx_octet,
  output logic             ser_o,
  output logic             underrun_o,
  output logic             overrun_o
);
  localparam logic [BIT_W-1:0] MSB_BIT = BIT_W'(OCTET_BITS - 1);

  octet_t rx_sh, tx_sh, tx_pick;
  logic   slot_start, slot_end, out_bit;

  assign slot_start = owned && (cur_bit == MSB_BIT);
  assign slot_end   = owned && (cur_bit == '0);
  assign tx_pick    = tx_have ? tx_head : IDLE_OCTET;
  assign tx_take    = slot_start && tx_have;
  assign rx_octet   = {rx_sh[OCTET_BITS-2:0], ser_i};
  assign rx_push    = slot_end && rx_room;

  always_comb begin
    if (!owned)          out_bit = ser_i;
    else if (slot_start) out_bit = tx_pick[OCTET_BITS-1];
    else                 out_bit = tx_sh[cur_bit];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh      <= '0;
      tx_sh      <= IDLE_OCTET;
      ser_o      <= 1'b1;
      underrun_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      rx_sh      <= rx_octet;
      if (slot_start) tx_sh <= tx_pick;
      ser_o      <= out_bit;
      underrun_o <= slot_start && !tx_have;
      overrun_o  <= slot_end && !rx_room;
    end
  end
endmodule

// File: rtl/e1_slot_mux.sv
module e1_slot_mux
  import e1_mux_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int RXF_DEPTH = 4,
  parameter int TXF_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] slot_mask,
  input  logic             fp_i,
  input  logic             ser_i,
  output logic             ser_o,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             underrun_o,
  output logic             overrun_o
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] cur_slot;
  logic [BIT_W-1:0]  cur_bit;
  logic [SLOTS-1:0]  own_map;
  logic              owned;
  octet_t            tx_head, rx_octet;
  logic              tx_have, tx_take, rx_room, rx_push;

  // Slot 0 carries framing and can never be owned.
  for (genvar g = 0; g < SLOTS; g++) begin : g_own
    if (g == 0) begin : g_frame
      assign own_map[g] = 1'b0;
    end else begin : g_data
      assign own_map[g] = slot_mask[g];
    end
  end
  assign owned = own_map[cur_slot];

  e1_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i),
    .cur_slot(cur_slot), .cur_bit(cur_bit)
  );

  e1_byte_fifo #(.DEPTH(TXF_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(tx_have), .out_ready(tx_take), .out_data(tx_head)
  );

  e1_byte_fifo #(.DEPTH(RXF_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_room), .in_data(rx_octet),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  e1_slot_lane u_lane (
    .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .owned(owned),
    .cur_bit(cur_bit), .tx_head(tx_head), .tx_have(tx_have),
    .tx_take(tx_take), .rx_room(rx_room), .rx_push(rx_push),
    .rx_octet(rx_octet), .ser_o(ser_o),
    .underrun_o(underrun_o), .overrun_o(overrun_o)
  );
endmodule

// File: rtl/e1_slot_mux_sva.sv
module e1_slot_mux_sva #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_i,
  input logic              ser_o,
  input logic              owned,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [2:0]        cur_bit,
  input logic [7:0]        rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              underrun_o,
  input logic              overrun_o
);
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !owned |=> ser_o == $past(ser_i));

  assert_slot0_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_slot == '0) |=> ser_o == $past(ser_i));

  assert_bit_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == 3'd0) |=> cur_bit == 3'd7);

  assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == 3'd0 && cur_slot == SLOT_W'(SLOTS - 1)) |=> cur_slot == '0);

  assert_idle_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> ser_o == 1'b1);

  assert_flag_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> !overrun_o);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data));
endmodule

bind e1_slot_mux e1_slot_mux_sva #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .ser_o(ser_o), .owned(owned),
  .cur_slot(cur_slot), .cur_bit(cur_bit), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .underrun_o(underrun_o), .overrun_o(overrun_o)
);

// File: tb/e1_slot_mux_bench.sv
module e1_slot_mux_bench;
  localparam int SLOTS = 32, RXD = 4, TXD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [SLOTS-1:0] slot_mask = '0;
  logic             fp_i = 1'b0, ser_i = 1'b1;
  logic             ser_o, rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
  logic [7:0]       rx_data, tx_data = '0;
  logic             underrun_o, overrun_o;

  e1_slot_mux #(.SLOTS(SLOTS), .RXF_DEPTH(RXD), .TXF_DEPTH(TXD)) u_e1_slot_mux (
    .clk(clk), .rst_n(rst_n), .slot_mask(slot_mask), .fp_i(fp_i), .ser_i(ser_i),
    .ser_o(ser_o), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .underrun_o(underrun_o), .overrun_o(overrun_o)
  );

  int vectors = 0, misses = 0;
  // reference model state
  int ms, mb, fcnt;
  logic [7:0] mcur;
  logic exp_ser, exp_und, exp_ovr;
  string exp_tag;
  logic [7:0] txq[$], rxq[$];
  // stimulus knobs
  int txv_pct, rxr_pct, inj_pct;
  bit fp_on;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_owned(int s);
    return (s != 0) && slot_mask[s];
  endfunction

  task automatic model_reset();
    ms = 0; mb = 7; fcnt = 0; mcur = 8'hFF;
    exp_ser = 1'b1; exp_und = 1'b0; exp_ovr = 1'b0; exp_tag = "R1";
    txq.delete(); rxq.delete();
  endtask

  task automatic drive_step();
    int s, b, rxsz;
    bit own, fp, txfull, injected;
    injected = ($urandom_range(0, 999) < inj_pct);
    fp = (fp_on && fcnt == 0) || injected;
    if (fp) fcnt = 0;
    fp_i     = fp;
    ser_i    = $urandom_range(0, 1);
    tx_valid = ($urandom_range(0, 99) < txv_pct);
    tx_data  = 8'($urandom);
    rx_ready = ($urandom_range(0, 99) < rxr_pct);
    // model of the upcoming clock edge, from the requirements
    s = fp ? 0 : ms;
    b = fp ? 7 : mb;
    own = is_owned(s);
    exp_und = 1'b0; exp_ovr = 1'b0;
    txfull = (txq.size() >= TXD);
    rxsz = rxq.size();
    if (own && b == 7) begin
      if (txq.size() > 0) mcur = txq.pop_front();
      else begin mcur = 8'hFF; exp_und = 1'b1; end
      exp_ser = mcur[7];
      exp_tag = exp_und ? "R7" : "R6";
    end else if (own) begin
      exp_ser = mcur[b];
    end else begin
      exp_ser = ser_i;
      exp_tag = (s == 0 && slot_mask[0]) ? "R3" : "R2";
    end
    if (injected) exp_tag = {exp_tag, " R11"};
    if (tx_valid && !txfull) txq.push_back(tx_data);
    if (rxsz > 0 && rx_ready) void'(rxq.pop_front());
    if (own && b == 0) begin
      if (rxsz < RXD) rxq.push_back({u_sh, ser_i});
      else exp_ovr = 1'b1;
    end
    u_sh = {u_sh[5:0], ser_i};
    if (b == 0) begin b = 7; s = (s == SLOTS - 1) ? 0 : s + 1; end
    else b--;
    ms = s; mb = b;
    fcnt = (fcnt + 1) % 256;
  endtask

  logic [6:0] u_sh = '0;

  task automatic cycle();
    @(negedge clk);
    chk({exp_tag, " R4 ser_o"}, {7'd0, ser_o}, {7'd0, exp_ser});
    chk("R7 underrun", {7'd0, underrun_o}, {7'd0, exp_und});
    chk("R8 overrun", {7'd0, overrun_o}, {7'd0, exp_ovr});
    chk("R10 tx_ready", {7'd0, tx_ready}, {7'd0, txq.size() < TXD});
    chk("R5 R9 rx_valid", {7'd0, rx_valid}, {7'd0, rxq.size() > 0});
    if (rxq.size() > 0) chk("R5 R9 rx_data", rx_data, rxq[0]);
    drive_step();
  endtask

  task automatic restart(input logic [SLOTS-1:0] m);
    @(negedge clk);
    rst_n = 1'b0; tx_valid = 1'b0; rx_ready = 1'b0; fp_i = 1'b0;
    slot_mask = m;
    repeat (3) @(negedge clk);
    chk("R1 ser_o", {7'd0, ser_o}, 8'd1);
    chk("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
    chk("R1 tx_ready", {7'd0, tx_ready}, 8'd1);
    chk("R1 flags", {6'd0, underrun_o, overrun_o}, 8'd0);
    model_reset();
    u_sh = '0;
    rst_n = 1'b1;
    drive_step();
  endtask

  initial begin
    #(8 * 190000);
    misses++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0E1));
    // random mask including slot 0 bit (R3), mixed traffic
    fp_on = 1; inj_pct = 0; txv_pct = 30; rxr_pct = 60;
    restart(32'($urandom) | 32'h1);
    repeat (1024) cycle();
    // starvation and back-pressure: underrun R7, overrun R8, hold R9
    txv_pct = 0; rxr_pct = 5;
    restart(32'hF0F0_0F0F);
    repeat (1024) cycle();
    // all data slots, full load: R6, R10
    txv_pct = 100; rxr_pct = 100;
    restart(32'hFFFF_FFFF);
    repeat (1024) cycle();
    txv_pct = 100; rxr_pct = 0;
    restart(32'h8000_0002);
    repeat (1024) cycle();
    // no frame pulse: free-run wrap R4; single top slot
    fp_on = 0; txv_pct = 50; rxr_pct = 50;
    restart(32'h8000_0000);
    repeat (1024) cycle();
    // mid-frame pulses: realignment R11
    fp_on = 1; inj_pct = 4; txv_pct = 40; rxr_pct = 70;
    restart(32'($urandom));
    repeat (3072) cycle();
    // random configurations
    inj_pct = 0;
    for (int k = 0; k < 6; k++) begin
      txv_pct = $urandom_range(0, 100); rxr_pct = $urandom_range(0, 100);
      restart(32'($urandom));
      repeat (768) cycle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule